// File: doc/BRIEF.md
# Translation Table Update Engine

This block carries out maintenance commands on a small DMA translation table held inside it. A command names a logical bus, a bus address, a value or a list pointer, and a page count. Four operations exist: write one entry, read one entry, write a run of pages with one repeated value, and write a run of pages from a list of entries fetched out of system memory. Each command ends with a single-cycle completion pulse. The pulse carries a success or parameter-error status and, for a read, the stored entry.

Each entry that is written produces a notification. It gives the page-aligned offset inside the window, the page-aligned target value and the two permission bits held in the entry. A translation path or a shadow table can use it to stay coherent. The list of entries is read through a one-outstanding request/response memory port. The engine takes one command at a time and shows this with a busy flag.

Top module: `xlate_update_engine`

## Requirements
- R1: A command whose bus number has any of bits 63:32 set, or whose bits 31:0 differ from the TABLE_ID parameter, ends with parameter-error status and writes nothing.
- R2: The bus address is first rounded down to a page boundary (PAGE_SHIFT). The entry index is (address − BUS_OFFSET) >> PAGE_SHIFT, using 64-bit unsigned arithmetic. An index of ENTRIES or more, including one that results from an address below the offset, gives a parameter error and no write.
- R3: Operation code 0 (put) stores cmdArg at the index and reports success. Operation code 1 (get) returns the stored entry on doneData with success. The table is all zero after reset.
- R4: A get that fails returns doneData equal to zero.
- R5: Every entry write produces exactly one notifyValid pulse. notifyIova is the page-aligned (address − BUS_OFFSET), notifyAddr is the page-aligned entry value, and notifyPerm is entry bits 1:0.
- R6: Operation code 2 (indirect put) rejects a count above MAX_LIST (512) and a list address with any of bits 11:0 set. Such a command issues no memory request.
- R7: Indirect put fetches element i from list + 8·i. The word is big-endian: the memory port returns the byte at address+k in bits 8k+7:8k, and the byte at the lowest address is the most significant. Element i is written to page base + i·page size.
- R8: Operation code 3 (stuff) rejects a count greater than ENTRIES. Otherwise it writes cmdArg to each of count consecutive pages starting at base.
- R9: A bulk command stops at the first out-of-range page with parameter error. Pages written before that stay written.
- R10: A bulk command with a count of zero ends with parameter error and writes nothing.
- R11: busy rises in the cycle after a command is accepted and stays high through the completion cycle. cmdValid while busy is ignored.
- R12: doneStatus is 0 for success and 1 for parameter error. doneValid is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present; accepted when busy is low |
| cmdOp | input | 2 | 0 put, 1 get, 2 indirect put, 3 stuff |
| cmdBusNum | input | 64 | Logical bus number |
| cmdIoAddr | input | 64 | Bus address of the first page |
| cmdArg | input | 64 | Entry value, or list address for indirect put |
| cmdCount | input | 32 | Page count for the bulk commands |
| busy | output | 1 | Command in progress |
| doneValid | output | 1 | Completion pulse |
| doneStatus | output | 1 | 0 success, 1 parameter error |
| doneData | output | 64 | Entry returned by get |
| memReqValid | output | 1 | List element read request |
| memReqAddr | output | 64 | Byte address of the element |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Read data, byte at address+k in lane k |
| notifyValid | output | 1 | Entry written |
| notifyIova | output | 64 | Page-aligned offset inside the window |
| notifyAddr | output | 64 | Page-aligned entry value |
| notifyPerm | output | 2 | Permission bits of the entry |

## Verification
The checker assumes the environment raises memRspValid only while a fetch is outstanding, one response per request. It also assumes cmdValid comes after reset is released. The bench memory model sends one response exactly two cycles after each request it sees, and sends nothing else. Stimulus changes only on falling edges. Random commands mix correct and wrong bus numbers and addresses below, inside and past the window. Counts range over zero, in-range values, and values just above ENTRIES and MAX_LIST. Directed cases cover a misaligned list and a command offered while busy.

// File: rtl/xlate_update_pkg.sv
package xlate_update_pkg;
  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    OP_PUT   = 2'd0,
    OP_GET   = 2'd1,
    OP_LIST  = 2'd2,
    OP_STUFF = 2'd3
  } cmdOp_e;

  typedef struct packed {
    logic loadCmd;
    logic writeEntry;
    logic selMem;
    logic stepPage;
    logic captureGet;
  } ctlStrobes_t;

  typedef struct packed {
    logic idMatch;
    logic idxOk;
    logic countZero;
    logic overTable;
    logic overList;
    logic listMisaligned;
    logic lastPage;
  } dpFlags_t;
endpackage

// File: rtl/xlate_update_dp.sv
module xlate_update_dp
  import xlate_update_pkg::*;
#(
  parameter int ENTRIES          = 16,
  parameter int PAGE_SHIFT       = 12,
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_8000_0000,
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int MAX_LIST         = 512,
  parameter int LIST_ALIGN_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [1:0]        cmdOp,
  input  logic [63:0]       cmdBusNum,
  input  logic [63:0]       cmdIoAddr,
  input  logic [63:0]       cmdArg,
  input  logic [31:0]       cmdCount,
  input  logic [63:0]       memRspData,
  output cmdOp_e            opQ,
  output dpFlags_t          flags,
  output logic [63:0]       memReqAddr,
  output logic [63:0]       getData,
  output logic              notifyValid,
  output logic [63:0]       notifyIova,
  output logic [63:0]       notifyAddr,
  output logic [1:0]        notifyPerm
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [63:0] PAGE_SIZE = 64'd1 << PAGE_SHIFT;
  localparam logic [63:0] PAGE_MASK = ~(PAGE_SIZE - 64'd1);

  logic [63:0] busNumQ, curAddrQ, argQ;
  logic [31:0] countQ, iterQ;
  logic [WORD_W-1:0] tableQ [ENTRIES];

  logic [63:0] winOffset, pageNum, memValue, wrValue;
  logic [IDX_W-1:0] idx;

  // big-endian assembly: lane 0 (lowest address) becomes the top byte
  for (genvar b = 0; b < 8; b++) begin : g_swap
    assign memValue[8*b +: 8] = memRspData[8*(7-b) +: 8];
  end

  assign winOffset = curAddrQ - BUS_OFFSET;
  assign pageNum   = winOffset >> PAGE_SHIFT;
  assign idx       = pageNum[IDX_W-1:0];
  assign wrValue   = strobes.selMem ? memValue : argQ;
  assign memReqAddr = argQ + {iterQ, 3'b000};

  always_comb begin
    flags.idMatch        = (busNumQ[63:32] == 32'd0) && (busNumQ[31:0] == TABLE_ID);
    flags.idxOk          = pageNum < 64'(ENTRIES);
    flags.countZero      = (countQ == 32'd0);
    flags.overTable      = countQ > 32'(ENTRIES);
    flags.overList       = countQ > 32'(MAX_LIST);
    flags.listMisaligned = (argQ[LIST_ALIGN_SHIFT-1:0] != '0);
    flags.lastPage       = (iterQ == countQ - 32'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ      <= OP_PUT;
      busNumQ  <= '0;
      curAddrQ <= '0;
      argQ     <= '0;
      countQ   <= '0;
      iterQ    <= '0;
    end else if (strobes.loadCmd) begin
      opQ      <= cmdOp_e'(cmdOp);
      busNumQ  <= cmdBusNum;
      curAddrQ <= cmdIoAddr & PAGE_MASK;
      argQ     <= cmdArg;
      countQ   <= cmdCount;
      iterQ    <= '0;
    end else if (strobes.stepPage) begin
      curAddrQ <= curAddrQ + PAGE_SIZE;
      iterQ    <= iterQ + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tableQ[i] <= '0;
    end else if (strobes.writeEntry) begin
      tableQ[idx] <= wrValue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) getData <= '0;
    else if (strobes.loadCmd) getData <= '0;
    else if (strobes.captureGet) getData <= tableQ[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      notifyValid <= 1'b0;
      notifyIova  <= '0;
      notifyAddr  <= '0;
      notifyPerm  <= '0;
    end else begin
      notifyValid <= strobes.writeEntry;
      if (strobes.writeEntry) begin
        notifyIova <= winOffset & PAGE_MASK;
        notifyAddr <= wrValue & PAGE_MASK;
        notifyPerm <= wrValue[1:0];
      end
    end
  end
endmodule

// File: rtl/xlate_update_ctrl.sv
module xlate_update_ctrl
  import xlate_update_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  cmdOp_e      opQ,
  input  dpFlags_t    flags,
  input  logic        memRspValid,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        doneValid,
  output logic        doneStatus,
  output logic        memReqValid
);
  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_STUFF, S_FETCH, S_WAIT, S_FIN
  } state_e;

  state_e stateQ, stateD;
  logic statusQ, statusD;

  always_comb begin
    stateD  = stateQ;
    statusD = statusQ;
    strobes = '0;
    unique case (stateQ)
      S_IDLE: if (cmdValid) begin
        strobes.loadCmd = 1'b1;
        stateD = S_DECODE;
      end
      S_DECODE: begin
        stateD  = S_FIN;
        statusD = 1'b1;
        if (flags.idMatch) begin
          unique case (opQ)
            OP_PUT: if (flags.idxOk) begin
              strobes.writeEntry = 1'b1;
              statusD = 1'b0;
            end
            OP_GET: if (flags.idxOk) begin
              strobes.captureGet = 1'b1;
              statusD = 1'b0;
            end
            OP_STUFF:
              if (!flags.countZero && !flags.overTable) stateD = S_STUFF;
            OP_LIST:
              if (!flags.countZero && !flags.overList && !flags.listMisaligned)
                stateD = S_FETCH;
            default: ;
          endcase
        end
      end
      S_STUFF: begin
        if (flags.idxOk) begin
          strobes.writeEntry = 1'b1;
          if (flags.lastPage) begin
            statusD = 1'b0;
            stateD  = S_FIN;
          end else begin
            strobes.stepPage = 1'b1;
          end
        end else begin
          statusD = 1'b1;
          stateD  = S_FIN;
        end
      end
      S_FETCH: stateD = S_WAIT;
      S_WAIT: if (memRspValid) begin
        if (flags.idxOk) begin
          strobes.writeEntry = 1'b1;
          strobes.selMem     = 1'b1;
          if (flags.lastPage) begin
            statusD = 1'b0;
            stateD  = S_FIN;
          end else begin
            strobes.stepPage = 1'b1;
            stateD = S_FETCH;
          end
        end else begin
          statusD = 1'b1;
          stateD  = S_FIN;
        end
      end
      S_FIN: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      statusQ <= 1'b1;
    end else begin
      stateQ  <= stateD;
      statusQ <= statusD;
    end
  end

  assign busy        = (stateQ != S_IDLE);
  assign doneValid   = (stateQ == S_FIN);
  assign doneStatus  = statusQ;
  assign memReqValid = (stateQ == S_FETCH);
endmodule

// File: rtl/xlate_update_engine.sv
module xlate_update_engine
  import xlate_update_pkg::*;
#(
  parameter int ENTRIES          = 16,
  parameter int PAGE_SHIFT       = 12,
  parameter logic [63:0] BUS_OFFSET = 64'h0000_0000_8000_0000,
  parameter logic [31:0] TABLE_ID   = 32'h8000_0001,
  parameter int MAX_LIST         = 512,
  parameter int LIST_ALIGN_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [63:0] cmdBusNum,
  input  logic [63:0] cmdIoAddr,
  input  logic [63:0] cmdArg,
  input  logic [31:0] cmdCount,
  output logic        busy,
  output logic        doneValid,
  output logic        doneStatus,
  output logic [63:0] doneData,
  output logic        memReqValid,
  output logic [63:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [63:0] memRspData,
  output logic        notifyValid,
  output logic [63:0] notifyIova,
  output logic [63:0] notifyAddr,
  output logic [1:0]  notifyPerm
);
  ctlStrobes_t strobes;
  dpFlags_t    flags;
  cmdOp_e      opQ;

  xlate_update_ctrl u_ctrl (
    .clk, .rstN, .cmdValid, .opQ, .flags, .memRspValid,
    .strobes, .busy, .doneValid, .doneStatus, .memReqValid
  );

  xlate_update_dp #(
    .ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT), .BUS_OFFSET(BUS_OFFSET),
    .TABLE_ID(TABLE_ID), .MAX_LIST(MAX_LIST), .LIST_ALIGN_SHIFT(LIST_ALIGN_SHIFT)
  ) u_dp (
    .clk, .rstN, .strobes, .cmdOp, .cmdBusNum, .cmdIoAddr, .cmdArg, .cmdCount,
    .memRspData, .opQ, .flags, .memReqAddr, .getData(doneData),
    .notifyValid, .notifyIova, .notifyAddr, .notifyPerm
  );
endmodule

// File: rtl/xlate_update_checker.sv
module xlate_update_checker #(
  parameter int PAGE_SHIFT = 12
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        busy,
  input logic        doneValid,
  input logic        doneStatus,
  input logic [63:0] doneData,
  input logic        memReqValid,
  input logic [63:0] memReqAddr,
  input logic        notifyValid,
  input logic [63:0] notifyIova,
  input logic [63:0] notifyAddr
);
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);
  p_done_while_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> busy);
  p_done_one_cycle_r12: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_done_then_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !busy);
  p_err_no_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneStatus) |-> (doneData == 64'd0));
  p_notify_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> (notifyIova[PAGE_SHIFT-1:0] == '0 && notifyAddr[PAGE_SHIFT-1:0] == '0));
  p_notify_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> busy);
  p_req_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);
  p_req_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (busy && memReqAddr[2:0] == 3'd0));
endmodule

bind xlate_update_engine xlate_update_checker #(.PAGE_SHIFT(PAGE_SHIFT)) u_checker (
  .clk, .rstN, .cmdValid, .busy, .doneValid, .doneStatus, .doneData,
  .memReqValid, .memReqAddr, .notifyValid, .notifyIova, .notifyAddr
);

// File: tb/xlate_update_engine_test.sv
module xlate_update_engine_test;
  localparam int ENTRIES = 16;
  localparam int PSHIFT  = 12;
  localparam logic [63:0] OFFS = 64'h0000_0000_8000_0000;
  localparam logic [31:0] TID  = 32'h8000_0001;
  localparam logic [63:0] PSIZE = 64'd1 << PSHIFT;
  localparam logic [63:0] PMASK = ~(PSIZE - 64'd1);
  localparam logic [63:0] GOODBUS = {32'd0, TID};

  logic clk = 0, rstN = 0;
  logic cmdValid = 0;
  logic [1:0] cmdOp = 0;
  logic [63:0] cmdBusNum = 0, cmdIoAddr = 0, cmdArg = 0;
  logic [31:0] cmdCount = 0;
  logic busy, doneValid, doneStatus, memReqValid, notifyValid;
  logic [63:0] doneData, memReqAddr, notifyIova, notifyAddr;
  logic [1:0] notifyPerm;
  logic memRspValid = 0;
  logic [63:0] memRspData = 0;

  always #5 clk = ~clk;

  xlate_update_engine uut (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdBusNum, .cmdIoAddr, .cmdArg, .cmdCount,
    .busy, .doneValid, .doneStatus, .doneData, .memReqValid, .memReqAddr,
    .memRspValid, .memRspData, .notifyValid, .notifyIova, .notifyAddr, .notifyPerm
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [63:0] shadow [ENTRIES];
  logic [63:0] expIova [600], expAddr [600];
  logic [1:0]  expPerm [600];
  logic [63:0] gotIova [600], gotAddr [600];
  logic [1:0]  gotPerm [600];
  int expN, gotN;
  logic expStatus;
  logic [63:0] expData;
  int reqCount;

  function automatic logic [63:0] listElem(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ {a[31:0], 32'h0000_0F0F};
  endfunction

  function automatic logic [63:0] toLanes(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

  // memory model: one response two cycles after each request
  logic pend = 0;
  logic [63:0] pendAddr = 0;
  always @(negedge clk) begin
    if (pend) begin
      memRspValid = 1;
      memRspData  = toLanes(listElem(pendAddr));
      pend = 0;
    end else begin
      memRspValid = 0;
    end
    if (memReqValid) begin
      pend = 1;
      pendAddr = memReqAddr;
      reqCount++;
    end
  end

  always @(negedge clk) begin
    if (notifyValid && gotN < 600) begin
      gotIova[gotN] = notifyIova;
      gotAddr[gotN] = notifyAddr;
      gotPerm[gotN] = notifyPerm;
      gotN++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns 1 and writes when in range (R2, R5)
  function automatic bit modelWrite(input logic [63:0] addr, input logic [63:0] val);
    logic [63:0] off = addr - OFFS;
    logic [63:0] pg = off >> PSHIFT;
    if (pg >= 64'(ENTRIES)) return 0;
    shadow[pg[3:0]] = val;
    expIova[expN] = off & PMASK;
    expAddr[expN] = val & PMASK;
    expPerm[expN] = val[1:0];
    expN++;
    return 1;
  endfunction

  task automatic modelCmd(input logic [1:0] op, input logic [63:0] bus, input logic [63:0] addr,
                          input logic [63:0] arg, input logic [31:0] cnt);
    logic [63:0] base = addr & PMASK;
    expN = 0; expStatus = 1; expData = 0;
    if (bus != GOODBUS) return;
    case (op)
      2'd0: expStatus = !modelWrite(base, arg);
      2'd1: begin
        logic [63:0] pg = (base - OFFS) >> PSHIFT;
        if (pg < 64'(ENTRIES)) begin expStatus = 0; expData = shadow[pg[3:0]]; end
      end
      2'd2: if (cnt != 0 && cnt <= 512 && arg[11:0] == 0) begin
        expStatus = 0;
        for (int i = 0; i < int'(cnt); i++)
          if (!modelWrite(base + 64'(i) * PSIZE, listElem(arg + 64'(8 * i)))) begin
            expStatus = 1; break;
          end
      end
      default: if (cnt != 0 && cnt <= ENTRIES) begin
        expStatus = 0;
        for (int i = 0; i < int'(cnt); i++)
          if (!modelWrite(base + 64'(i) * PSIZE, arg)) begin expStatus = 1; break; end
      end
    endcase
  endtask

  task automatic issue(input logic [1:0] op, input logic [63:0] bus, input logic [63:0] addr,
                       input logic [63:0] arg, input logic [31:0] cnt);
    gotN = 0; reqCount = 0;
    cmdOp = op; cmdBusNum = bus; cmdIoAddr = addr; cmdArg = arg; cmdCount = cnt;
    cmdValid = 1;
    @(negedge clk);
    cmdValid = 0;
  endtask

  task automatic finishCheck(input string req);
    int guard = 0;
    while (!doneValid && guard < 5000) begin @(negedge clk); guard++; end
    check(doneValid, {req, " done"}, 64'(doneValid), 64'd1);
    check(doneStatus == expStatus, {req, " R12 status"}, 64'(doneStatus), 64'(expStatus));
    check(doneData == expData, {req, " R3/R4 data"}, doneData, expData);
    @(negedge clk);
    check(!busy, {req, " R11 idle after done"}, 64'(busy), 64'd0);
    check(gotN == expN, {req, " R5 notify count"}, 64'(gotN), 64'(expN));
    for (int i = 0; i < expN && i < gotN; i++)
      check(gotIova[i] == expIova[i] && gotAddr[i] == expAddr[i] && gotPerm[i] == expPerm[i],
            {req, " R5 notify fields"}, gotAddr[i] ^ gotIova[i], expAddr[i] ^ expIova[i]);
  endtask

  task automatic runCmd(input string req, input logic [1:0] op, input logic [63:0] bus,
                        input logic [63:0] addr, input logic [63:0] arg, input logic [31:0] cnt);
    modelCmd(op, bus, addr, arg, cnt);
    issue(op, bus, addr, arg, cnt);
    finishCheck(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < ENTRIES; i++) shadow[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!busy && !doneValid && !notifyValid && !memReqValid, "reset R11",
          {busy, doneValid, notifyValid, memReqValid}, 0);

    runCmd("R3 get after reset", 2'd1, GOODBUS, OFFS + 3 * PSIZE, 0, 0);
    runCmd("R3 put", 2'd0, GOODBUS, OFFS + 5 * PSIZE + 64'h123, 64'hABCD_0000_1234_5003, 0);
    runCmd("R2 get unaligned addr", 2'd1, GOODBUS, OFFS + 5 * PSIZE + 64'hFFF, 0, 0);
    runCmd("R1 high bus bits", 2'd0, GOODBUS | (64'd1 << 40), OFFS, 64'h7, 0);
    runCmd("R1 wrong id", 2'd0, GOODBUS ^ 64'd2, OFFS, 64'h7, 0);
    runCmd("R2 index at limit", 2'd0, GOODBUS, OFFS + ENTRIES * PSIZE, 64'h5, 0);
    runCmd("R2 below offset", 2'd0, GOODBUS, OFFS - 64'd1, 64'h5, 0);
    runCmd("R4 get out of range", 2'd1, GOODBUS, OFFS + 20 * PSIZE, 0, 0);
    runCmd("R8 stuff full", 2'd3, GOODBUS, OFFS, 64'h0000_0000_4444_5002, ENTRIES);
    runCmd("R8 stuff over", 2'd3, GOODBUS, OFFS, 64'h1, ENTRIES + 1);
    runCmd("R10 stuff zero", 2'd3, GOODBUS, OFFS, 64'h1, 0);
    runCmd("R9 stuff runs off end", 2'd3, GOODBUS, OFFS + 13 * PSIZE, 64'h9_9001, 5);
    runCmd("R7 indirect", 2'd2, GOODBUS, OFFS + 2 * PSIZE, 64'h0001_2000, 4);
    runCmd("R9 indirect runs off end", 2'd2, GOODBUS, OFFS + 14 * PSIZE, 64'h0003_0000, 512);
    check(reqCount == 3, "R9 fetch stops at failing page", 64'(reqCount), 64'd3);
    runCmd("R6 indirect over limit", 2'd2, GOODBUS, OFFS, 64'h0004_0000, 513);
    check(reqCount == 0, "R6 no fetch", 64'(reqCount), 64'd0);
    runCmd("R6 indirect misaligned", 2'd2, GOODBUS, OFFS, 64'h0004_0008, 2);
    check(reqCount == 0, "R6 no fetch misaligned", 64'(reqCount), 64'd0);
    runCmd("R10 indirect zero", 2'd2, GOODBUS, OFFS, 64'h0004_0000, 0);

    // R11: a command offered while busy has no effect
    modelCmd(2'd2, GOODBUS, OFFS, 64'h0005_0000, 2);
    issue(2'd2, GOODBUS, OFFS, 64'h0005_0000, 2);
    cmdOp = 2'd0; cmdIoAddr = OFFS + 9 * PSIZE; cmdArg = 64'hDEAD_0000_0000_0003;
    cmdValid = 1;
    for (int i = 0; i < 3; i++) begin
      check(busy, "R11 busy held", 64'(busy), 64'd1);
      @(negedge clk);
    end
    cmdValid = 0;
    finishCheck("R11 indirect under load");
    runCmd("R11 ignored put left entry", 2'd1, GOODBUS, OFFS + 9 * PSIZE, 0, 0);

    for (int n = 0; n < 250; n++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [63:0] bus = ($urandom_range(0, 9) == 0) ? (GOODBUS ^ 64'($urandom_range(1, 255))) : GOODBUS;
      logic [63:0] addr = ($urandom_range(0, 15) == 0) ? OFFS - PSIZE
                          : OFFS + 64'($urandom_range(0, 19)) * PSIZE + 64'($urandom_range(0, 4095));
      logic [63:0] arg;
      logic [31:0] cnt;
      if (op == 2'd2) begin
        arg = {44'($urandom_range(0, 255)), 20'h0} | (($urandom_range(0, 7) == 0) ? 64'h8 : 64'h0);
        cnt = ($urandom_range(0, 9) == 0) ? 32'd513 : 32'($urandom_range(0, 6));
      end else begin
        arg = {$urandom, $urandom};
        cnt = 32'($urandom_range(0, ENTRIES + 2));
      end
      runCmd("random R3 R5 R7 R8 R9", op, bus, addr, arg, cnt);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule